// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide synchronous register bus. Each pin has two registers. The pad-control register sets the direction, the drive style, the resistor enable, the pull selection and the output level. The sense register reports the synchronised pin level and holds the edge type that raises an event.

Events land in two status bytes of unequal size. Pins 0–6 form group 0 and pins 7–12 form group 1. Software clears a status bit by writing a one to it. Two mask bytes decide which status bits reach the single level interrupt output. A host reads and writes the registers, routes the pad signals to the I/O ring, and services `irq` by reading the two adjacent status bytes in one burst.

Top module: `pgpio_ctrl`

## Requirements
- R1: After synchronous reset, every pin is an input (`pin_oe` all 0) and every pad-control register reads 0. Every sense register reads 0 in bits 2:1, which means detection is off. Status bytes read 0, mask bytes read all ones for their valid bits, and `irq` is 0.
- R2: Address map:
  - pad-control registers for pins 0–12 sit at addresses 0–12;
  - sense registers for pins 0–12 sit at addresses 13–25;
  - status bytes for group 0 and group 1 sit at 26 and 27;
  - mask bytes for group 0 and group 1 sit at 28 and 29.
  A pin's bit inside a group byte is the pin number minus the group's first pin (0 or 7). Unused addresses read 0.
- R3: Pad-control byte fields:
  - bit 0 is the output level;
  - bits 2:1 select the pull and appear on `pin_pull_sel[2p+1:2p]`;
  - bit 3 enables the resistor and appears on `pin_pull_en`;
  - bit 4 selects the drive, 1 for push-pull and 0 for open-drain;
  - bit 5 selects the direction, 1 for output.
  With bit 5 at 0 the pin is never driven. With push-pull output, `pin_oe`=1 and `pin_out` equals bit 0.
- R4: With open-drain output, a level of 1 releases the pin (`pin_oe`=0). A level of 0 drives it low (`pin_oe`=1, `pin_out`=0).
- R5: Sense register bit 0 reads the pin level after a two-flop synchroniser. Bits 2:1 read back the edge select, and the other bits read 0.
- R6: Edge select codes are 0 = off, 1 = falling, 2 = rising and 3 = both edges. A matching edge on the synchronised level sets the pin's status bit.
- R7: Writing a 1 to a status bit clears it. Writing 0 leaves it unchanged. Without an edge or a write, status holds.
- R8: An edge detected in the same cycle as a clear of that bit leaves the bit set.
- R9: `irq` is 1 exactly when some status bit is set whose mask bit is 0. A mask bit of 1 blocks that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid after the next edge |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 13 | Asynchronous pin levels |
| pin_out | output | 13 | Pad output level |
| pin_oe | output | 13 | Pad output enable |
| pin_pull_en | output | 13 | Pad resistor enable |
| pin_pull_sel | output | 26 | Pad pull select, two bits per pin |
| irq | output | 1 | Combined level interrupt |

## Verification
A synchronised edge and a software write-one-to-clear can hit the same status bit in the same cycle. The bench provokes this by changing a pin whose detector is set to both edges. It counts the two synchroniser stages, then places the clear write on the very edge at which the event registers. A follow-up read must show the bit still set, and a second, isolated clear must then empty it.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       dir_out;
        logic       push_pull;
        logic       res_en;
        logic [1:0] pull;
        logic       level;
    } padctl_t;

    function automatic logic edge_hit(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            EDGE_FALL: hit = prev & ~cur;
            EDGE_RISE: hit = ~prev & cur;
            EDGE_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pgpio_pin.sv
module pgpio_pin
    import pgpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pad_we,
    input  logic       sense_we,
    input  logic [5:0] pad_wd,
    input  logic [1:0] mode_wd,
    input  logic       lvl,
    output padctl_t    pad_q,
    output edge_mode_e mode_q,
    output logic       evt,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pull_en,
    output logic [1:0] pull_sel
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q  <= '0;
            mode_q <= EDGE_OFF;
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            if (pad_we)
                pad_q <= padctl_t'({2'b00, pad_wd});
            if (sense_we)
                mode_q <= edge_mode_e'(mode_wd);
        end
    end

    assign evt = edge_hit(mode_q, prev_q, lvl);

    always_comb begin
        if (pad_q.push_pull) begin
            pad_oe  = pad_q.dir_out;
            pad_out = pad_q.level;
        end else begin
            pad_oe  = pad_q.dir_out & ~pad_q.level;
            pad_out = 1'b0;
        end
    end

    assign pull_en  = pad_q.res_en;
    assign pull_sel = pad_q.pull;
endmodule

// File: rtl/pgpio_irq.sv
module pgpio_irq #(
    parameter int NUM_PINS  = 13,
    parameter int GRP0_PINS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] evt,
    input  logic                stat0_we,
    input  logic                stat1_we,
    input  logic                mask0_we,
    input  logic                mask1_we,
    input  logic [7:0]          wdata,
    output logic [NUM_PINS-1:0] stat_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic                irq
);
    localparam logic [NUM_PINS-1:0] G0_SEL = NUM_PINS'((1 << GRP0_PINS) - 1);
    localparam logic [NUM_PINS-1:0] G1_SEL = ~G0_SEL;

    logic [NUM_PINS-1:0] wd_g0, wd_g1, clr, mask_d;

    assign wd_g0 = NUM_PINS'(wdata) & G0_SEL;
    assign wd_g1 = (NUM_PINS'(wdata) << GRP0_PINS) & G1_SEL;

    always_comb begin
        clr = '0;
        if (stat0_we) clr = clr | wd_g0;
        if (stat1_we) clr = clr | wd_g1;
        mask_d = mask_q;
        if (mask0_we) mask_d = (mask_d & ~G0_SEL) | wd_g0;
        if (mask1_we) mask_d = (mask_d & ~G1_SEL) | wd_g1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= (stat_q & ~clr) | evt;
            mask_q <= mask_d;
        end
    end

    assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/pgpio_ctrl.sv
module pgpio_ctrl
    import pgpio_pkg::*;
#(
    parameter int NUM_PINS  = 13,
    parameter int GRP0_PINS = 7,
    parameter int ADDR_W    = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_pull_en,
    output logic [2*NUM_PINS-1:0] pin_pull_sel,
    output logic                  irq
);
    localparam int PAD_BASE   = 0;
    localparam int SENSE_BASE = PAD_BASE + NUM_PINS;
    localparam int STAT_BASE  = SENSE_BASE + NUM_PINS;
    localparam int MASK_BASE  = STAT_BASE + 2;

    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] dir_vec;
    logic [NUM_PINS-1:0] stat_q, mask_q;
    padctl_t             pad_v  [NUM_PINS];
    edge_mode_e          mode_v [NUM_PINS];
    logic [7:0]          rd_mux;

    pgpio_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic pad_we, sense_we;
        assign pad_we   = bus_wr && (bus_addr == ADDR_W'(PAD_BASE + p));
        assign sense_we = bus_wr && (bus_addr == ADDR_W'(SENSE_BASE + p));

        pgpio_pin u_pin (
            .clk      (clk),
            .rst      (rst),
            .pad_we   (pad_we),
            .sense_we (sense_we),
            .pad_wd   (bus_wdata[5:0]),
            .mode_wd  (bus_wdata[2:1]),
            .lvl      (lvl[p]),
            .pad_q    (pad_v[p]),
            .mode_q   (mode_v[p]),
            .evt      (evt[p]),
            .pad_out  (pin_out[p]),
            .pad_oe   (pin_oe[p]),
            .pull_en  (pin_pull_en[p]),
            .pull_sel (pin_pull_sel[2*p +: 2])
        );
        assign dir_vec[p] = pad_v[p].dir_out;
    end

    pgpio_irq #(.NUM_PINS(NUM_PINS), .GRP0_PINS(GRP0_PINS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .stat0_we (bus_wr && (bus_addr == ADDR_W'(STAT_BASE))),
        .stat1_we (bus_wr && (bus_addr == ADDR_W'(STAT_BASE + 1))),
        .mask0_we (bus_wr && (bus_addr == ADDR_W'(MASK_BASE))),
        .mask1_we (bus_wr && (bus_addr == ADDR_W'(MASK_BASE + 1))),
        .wdata    (bus_wdata),
        .stat_q   (stat_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_W'(PAD_BASE + p))
                rd_mux = pad_v[p];
            if (bus_addr == ADDR_W'(SENSE_BASE + p))
                rd_mux = {5'b0, mode_v[p], lvl[p]};
        end
        if (bus_addr == ADDR_W'(STAT_BASE))
            rd_mux = 8'(stat_q[GRP0_PINS-1:0]);
        if (bus_addr == ADDR_W'(STAT_BASE + 1))
            rd_mux = 8'(stat_q[NUM_PINS-1:GRP0_PINS]);
        if (bus_addr == ADDR_W'(MASK_BASE))
            rd_mux = 8'(mask_q[GRP0_PINS-1:0]);
        if (bus_addr == ADDR_W'(MASK_BASE + 1))
            rd_mux = 8'(mask_q[NUM_PINS-1:GRP0_PINS]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/pgpio_ctrl_chk.sv
module pgpio_ctrl_chk #(
    parameter int NUM_PINS  = 13,
    parameter int GRP0_PINS = 7,
    parameter int ADDR_W    = 6,
    parameter int STAT_BASE = 26
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_wdata,
    input logic                irq,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] dir_vec,
    input logic [NUM_PINS-1:0] evt,
    input logic [NUM_PINS-1:0] stat_q,
    input logic [NUM_PINS-1:0] mask_q
);
    localparam logic [NUM_PINS-1:0] G0 = NUM_PINS'((1 << GRP0_PINS) - 1);

    logic clr0;
    assign clr0 = bus_wr && (bus_addr == ADDR_W'(STAT_BASE));

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && stat_q == '0)); // R1

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~dir_vec) == '0); // R3

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr0 |=> ((stat_q & NUM_PINS'($past(bus_wdata)) & G0 & ~$past(evt)) == '0)); // R7

    AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && evt == '0) |=> $stable(stat_q)); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~mask_q) == '0) |-> !irq); // R9

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~mask_q) != '0) |-> irq); // R9
endmodule

bind pgpio_ctrl pgpio_ctrl_chk #(
    .NUM_PINS  (NUM_PINS),
    .GRP0_PINS (GRP0_PINS),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .dir_vec   (dir_vec),
    .evt       (evt),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/pgpio_ctrl_tb.sv
module pgpio_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [12:0] pin_in = '0;
    logic [12:0] pin_out, pin_oe, pin_pull_en;
    logic [25:0] pin_pull_sel;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgpio_ctrl u_dut (
        .clk (clk), .rst (rst),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .pin_pull_en (pin_pull_en), .pin_pull_sel (pin_pull_sel),
        .irq (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, 32'(d), 32'(exp));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        rd_chk("R1 pad0", 6'd0, 8'h00);
        rd_chk("R1 pad12", 6'd12, 8'h00);
        rd_chk("R1 sense5", 6'd18, 8'h00);
        rd_chk("R1 stat0", 6'd26, 8'h00);
        rd_chk("R1 stat1", 6'd27, 8'h00);
        rd_chk("R1 mask0", 6'd28, 8'h7F);
        rd_chk("R1 mask1", 6'd29, 8'h3F);
        rd_chk("R2 unused30", 6'd30, 8'h00);
        rd_chk("R2 unused63", 6'd63, 8'h00);
    endtask

    task automatic t_pad();
        wr(6'd3, 8'h39);
        chk("R3 pp oe", 32'(pin_oe[3]), 1);
        chk("R3 pp out", 32'(pin_out[3]), 1);
        chk("R3 res_en", 32'(pin_pull_en[3]), 1);
        chk("R3 pull0", 32'(pin_pull_sel[7:6]), 0);
        wr(6'd3, 8'h36);
        chk("R3 pp oe low", 32'(pin_oe[3]), 1);
        chk("R3 pp out low", 32'(pin_out[3]), 0);
        chk("R3 res off", 32'(pin_pull_en[3]), 0);
        chk("R3 pull3", 32'(pin_pull_sel[7:6]), 3);
        rd_chk("R3 readback", 6'd3, 8'h36);
        wr(6'd12, 8'h1B);
        chk("R3 input undriven", 32'(pin_oe[12]), 0);
        chk("R3 pull1", 32'(pin_pull_sel[25:24]), 1);
    endtask

    task automatic t_od();
        wr(6'd5, 8'h21);
        chk("R4 od release", 32'(pin_oe[5]), 0);
        wr(6'd5, 8'h20);
        chk("R4 od drive oe", 32'(pin_oe[5]), 1);
        chk("R4 od drive low", 32'(pin_out[5]), 0);
    endtask

    task automatic t_sense();
        pin_in[9] = 1'b1;
        settle();
        rd_chk("R5 level", 6'd22, 8'h01);
        wr(6'd22, 8'hFC);
        rd_chk("R5 mode readback", 6'd22, 8'h05);
        wr(6'd22, 8'h00);
        pin_in[9] = 1'b0;
        settle();
        rd_chk("R5 level low", 6'd22, 8'h00);
    endtask

    task automatic t_edges();
        wr(6'd15, 8'h04);
        wr(6'd21, 8'h02);
        wr(6'd23, 8'h06);
        wr(6'd28, 8'h00);
        wr(6'd29, 8'h00);
        pin_in[2] = 1'b1; pin_in[8] = 1'b1; pin_in[10] = 1'b1; pin_in[4] = 1'b1;
        settle();
        rd_chk("R6 rise g0", 6'd26, 8'h04);
        rd_chk("R6 rise g1", 6'd27, 8'h08);
        chk("R9 irq set", 32'(irq), 1);
        wr(6'd26, 8'h04);
        wr(6'd27, 8'h08);
        rd_chk("R7 cleared g0", 6'd26, 8'h00);
        rd_chk("R7 cleared g1", 6'd27, 8'h00);
        chk("R9 irq clear", 32'(irq), 0);
        pin_in[2] = 1'b0; pin_in[8] = 1'b0; pin_in[10] = 1'b0; pin_in[4] = 1'b0;
        settle();
        rd_chk("R6 fall g0", 6'd26, 8'h00);
        rd_chk("R6 fall g1", 6'd27, 8'h0A);
        wr(6'd27, 8'h02);
        rd_chk("R7 zero keeps", 6'd27, 8'h08);
        wr(6'd27, 8'h08);
        rd_chk("R7 second clear", 6'd27, 8'h00);
    endtask

    task automatic t_mask();
        wr(6'd28, 8'h04);
        pin_in[2] = 1'b1;
        settle();
        rd_chk("R9 stat while masked", 6'd26, 8'h04);
        chk("R9 masked irq", 32'(irq), 0);
        wr(6'd28, 8'h00);
        chk("R9 unmasked irq", 32'(irq), 1);
        wr(6'd29, 8'h3F);
        rd_chk("R9 mask1 readback", 6'd29, 8'h3F);
        wr(6'd26, 8'h04);
        chk("R9 irq after clear", 32'(irq), 0);
        pin_in[2] = 1'b0;
        settle();
    endtask

    task automatic t_collide();
        @(negedge clk);
        pin_in[10] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'd27; bus_wdata = 8'h08;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R8 edge beats clear", 6'd27, 8'h08);
        wr(6'd27, 8'h08);
        rd_chk("R8 later clear", 6'd27, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pad();
        t_od();
        t_sense();
        t_edges();
        t_mask();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule